// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

The controller manages a set of general-purpose pins split into banks of 32. Every pin has a direction bit, an output latch bit, a synchronised input reading, a rising-edge enable, a falling-edge enable and an interrupt status bit. A pin number `p` belongs to bank `p/32` at bit `p%32`. Software reaches all of this through a small word-addressed register bus: address, write strobe, write data and combinational read data.

The output latch and both edge-enable masks have no plain write port. Each is changed through a pair of ports: a write-one-to-set port and a write-one-to-clear port. This lets two agents change different bits without a read-modify-write race. Input levels pass through a two-flop synchroniser. An enabled edge latches a status bit, and software clears that bit by writing a one to it.

Interrupts are gated per bank. A global enable register holds one bit per bank. A bank's interrupt line is high when that bank's bit is set and the bank has any pending status bit. Pin drivers are controlled through a per-pin output-enable.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every direction bit is 1 (all pins inputs, `pin_oe` all 0). The output latches, both edge-enable masks, all status bits and the bank enables are 0, and every `irq` line is low.
- R2: Direction register (bank offset 0) is read/write. A bit of 0 asserts `pin_oe` for that pin, so the pin drives. A bit of 1 makes the pin an input.
- R3: A write to the output-set port (offset 2) sets each latch bit where the data has a 1 and leaves the other bits unchanged. Offsets 1, 2 and 3 all read back the latch, and the latch drives `pin_out`. A write to offset 1 has no effect.
- R4: A write to the output-clear port (offset 3) clears each latch bit where the data has a 1 and leaves the other bits unchanged.
- R5: Offset 4 returns the pin levels after a two-flop synchroniser. A level applied before clock edge k is readable after edge k+1.
- R6: The rising-edge enable is set through offset 5 and cleared through offset 6, with write-one semantics on both. Reading either offset returns the enable mask.
- R7: The falling-edge enable is set through offset 7 and cleared through offset 8, with write-one semantics on both. Reading either offset returns the enable mask.
- R8: A synchronised edge of an enabled type sets the pin's status bit (offset 9). For an input change before edge k, the bit is visible after edge k+2. An edge of a type not enabled for that pin leaves the status bit at 0.
- R9: Writing to the status register clears each bit where the data has a 1 and leaves the other bits unchanged.
- R10: When a new enabled edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: Global word 1 holds the bank enables, one read/write bit per bank (bit b for bank b). `irq[b]` is high exactly when bank b's enable bit is set and its status register is nonzero.
- R12: Global word 0 reads the constant 32'h0B10_0C01, and writes to it are ignored.
- R13: Bank b's registers sit at word address 16*(b+1)+offset. Pin p appears at bit p%32 of bank p/32 and at index p of `pin_in`, `pin_out` and `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_BANKS*BANK_W | Pin levels, asynchronous |
| pin_out | output | NUM_BANKS*BANK_W | Output latch values |
| pin_oe | output | NUM_BANKS*BANK_W | Pin drive enable (inverse of direction) |
| irq | output | NUM_BANKS | Per-bank interrupt |

## Verification
The register table uses set and clear masks that overlap the bits already held. A plain overwrite, or a port that toggles instead of setting or clearing, therefore gives a different readback than the correct OR or AND-NOT update. Pin toggles on pins with the enable bit on and pins with it off separate edge gating from raw edge capture. Toggles of both polarities catch a swapped rising and falling polarity. Counting clock edges between the pin change and the readback catches a synchroniser or detector that is one stage short or long. A clear timed onto the edge-capture cycle shows whether status capture has priority over clearing. Toggling the bank enable while status is held shows the interrupt is gated per bank.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int OFF_W = 4;

    // per-bank register offsets (word addresses inside a 16-word window)
    localparam logic [OFF_W-1:0] OFF_DIR  = 4'd0;
    localparam logic [OFF_W-1:0] OFF_OUT  = 4'd1;
    localparam logic [OFF_W-1:0] OFF_OSET = 4'd2;
    localparam logic [OFF_W-1:0] OFF_OCLR = 4'd3;
    localparam logic [OFF_W-1:0] OFF_IN   = 4'd4;
    localparam logic [OFF_W-1:0] OFF_RSET = 4'd5;
    localparam logic [OFF_W-1:0] OFF_RCLR = 4'd6;
    localparam logic [OFF_W-1:0] OFF_FSET = 4'd7;
    localparam logic [OFF_W-1:0] OFF_FCLR = 4'd8;
    localparam logic [OFF_W-1:0] OFF_STAT = 4'd9;

    // global window offsets
    localparam logic [OFF_W-1:0] GOFF_ID  = 4'd0;
    localparam logic [OFF_W-1:0] GOFF_BEN = 4'd1;

    localparam logic [31:0] CTRL_ID = 32'h0B10_0C01;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [BANK_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic [BANK_W-1:0] lvl_sync,
    output logic [BANK_W-1:0] rd_data,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] out_q,
    output logic [BANK_W-1:0] rise_q,
    output logic [BANK_W-1:0] stat_q
);
    logic [BANK_W-1:0] fall_q;
    logic [BANK_W-1:0] lvl_prev;
    logic [BANK_W-1:0] edge_hit;
    logic [BANK_W-1:0] stat_clr;

    // control registers with atomic set/clear ports
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_en) begin
            unique case (wr_off)
                OFF_DIR:  dir_q  <= wr_data;
                OFF_OSET: out_q  <= out_q  |  wr_data;
                OFF_OCLR: out_q  <= out_q  & ~wr_data;
                OFF_RSET: rise_q <= rise_q |  wr_data;
                OFF_RCLR: rise_q <= rise_q & ~wr_data;
                OFF_FSET: fall_q <= fall_q |  wr_data;
                OFF_FCLR: fall_q <= fall_q & ~wr_data;
                default:  ;
            endcase
        end
    end

    // edge detection against the previous synchronised sample
    assign edge_hit = ( lvl_sync & ~lvl_prev & rise_q)
                    | (~lvl_sync &  lvl_prev & fall_q);
    assign stat_clr = (wr_en && wr_off == OFF_STAT) ? wr_data : '0;

    // a fresh edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev <= '0;
            stat_q   <= '0;
        end else begin
            lvl_prev <= lvl_sync;
            stat_q   <= (stat_q & ~stat_clr) | edge_hit;
        end
    end

    always_comb begin
        unique case (rd_off)
            OFF_DIR:                     rd_data = dir_q;
            OFF_OUT, OFF_OSET, OFF_OCLR: rd_data = out_q;
            OFF_IN:                      rd_data = lvl_sync;
            OFF_RSET, OFF_RCLR:          rd_data = rise_q;
            OFF_FSET, OFF_FCLR:          rd_data = fall_q;
            OFF_STAT:                    rd_data = stat_q;
            default:                     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    output logic [NUM_BANKS-1:0]        irq
);
    localparam int NPINS = NUM_BANKS * BANK_W;
    localparam int SEL_W = ADDR_W - OFF_W;

    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    logic [NPINS-1:0] lvl_sync;
    logic [NUM_BANKS-1:0] bank_en;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_rd;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_dir;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_out;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_rise;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_stat;

    assign sel = bus_addr[ADDR_W-1:OFF_W];
    assign off = bus_addr[OFF_W-1:0];

    gpio_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_we && (sel == SEL_W'(b + 1));

        gpio_bank #(.BANK_W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .wr_off   (off),
            .wr_data  (bus_wdata),
            .rd_off   (off),
            .lvl_sync (lvl_sync[b*BANK_W +: BANK_W]),
            .rd_data  (bank_rd[b]),
            .dir_q    (bank_dir[b]),
            .out_q    (bank_out[b]),
            .rise_q   (bank_rise[b]),
            .stat_q   (bank_stat[b])
        );

        assign pin_out[b*BANK_W +: BANK_W] = bank_out[b];
        assign pin_oe[b*BANK_W +: BANK_W]  = ~bank_dir[b];
        assign irq[b] = bank_en[b] && (|bank_stat[b]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_en <= '0;
        end else if (bus_we && sel == '0 && off == GOFF_BEN) begin
            bank_en <= bus_wdata[NUM_BANKS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel == '0) begin
            if (off == GOFF_ID)
                bus_rdata = BANK_W'(CTRL_ID);
            else if (off == GOFF_BEN)
                bus_rdata = {{(BANK_W-NUM_BANKS){1'b0}}, bank_en};
        end else begin
            for (int b = 0; b < NUM_BANKS; b++)
                if (sel == SEL_W'(b + 1))
                    bus_rdata = bank_rd[b];
        end
    end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic [BANK_W-1:0]           bus_wdata,
    input logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    input logic [NUM_BANKS-1:0]        irq,
    input logic [BANK_W-1:0]           b0_out,
    input logic [BANK_W-1:0]           b0_rise,
    input logic [BANK_W-1:0]           b0_stat
);
    localparam int SEL_W = ADDR_W - OFF_W;

    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    logic             b0_sel;
    logic             dir_wr;
    logic [BANK_W-1:0] out_mask;
    logic [BANK_W-1:0] rise_mask;
    logic [BANK_W-1:0] stat_mask;

    assign sel       = bus_addr[ADDR_W-1:OFF_W];
    assign off       = bus_addr[OFF_W-1:0];
    assign b0_sel    = bus_we && sel == SEL_W'(1);
    assign dir_wr    = bus_we && sel != '0 && off == OFF_DIR;
    assign out_mask  = (b0_sel && (off == OFF_OSET || off == OFF_OCLR)) ? bus_wdata : '0;
    assign rise_mask = (b0_sel && (off == OFF_RSET || off == OFF_RCLR)) ? bus_wdata : '0;
    assign stat_mask = (b0_sel && off == OFF_STAT) ? bus_wdata : '0;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && irq == '0)); // R1
    AST_OE_ONLY_ON_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dir_wr) |-> $stable(pin_oe)); // R2
    AST_OUT_ONLY_BY_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((b0_out ^ $past(b0_out)) & ~$past(out_mask)) == '0); // R3
    AST_RISE_ONLY_BY_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((b0_rise ^ $past(b0_rise)) & ~$past(rise_mask)) == '0); // R6
    AST_STAT_FALL_ONLY_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(b0_stat) & ~b0_stat & ~$past(stat_mask)) == '0); // R9
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .b0_out    (bank_out[0]),
    .b0_rise   (bank_rise[0]),
    .b0_stat   (bank_stat[0])
);

// File: tb/gpio_ctrl_tb_top.sv
module gpio_ctrl_tb_top;
    localparam int NB = 2;
    localparam int BW = 32;
    localparam int NV = 26;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;   // write data, or expected read data
    } vec_t;

    // R3 R4 R6 R7 R11 R12 R13: register table
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h10, 32'h0000_FFFF},  // R2 dir bank0
        '{1'b0, 8'h10, 32'h0000_FFFF},  // R2
        '{1'b1, 8'h12, 32'hA5A5_0F0F},  // R3 set
        '{1'b0, 8'h11, 32'hA5A5_0F0F},  // R3
        '{1'b1, 8'h12, 32'h0000_F000},  // R3 set overlapping
        '{1'b0, 8'h13, 32'hA5A5_FF0F},  // R3 read via clear port
        '{1'b1, 8'h13, 32'h0F0F_0F00},  // R4 clear
        '{1'b0, 8'h11, 32'hA0A0_F00F},  // R4
        '{1'b1, 8'h11, 32'hFFFF_FFFF},  // R3 write to readback ignored
        '{1'b0, 8'h11, 32'hA0A0_F00F},  // R3
        '{1'b1, 8'h25, 32'h8000_0001},  // R6 bank1 rise set
        '{1'b1, 8'h25, 32'h0000_0100},  // R6
        '{1'b0, 8'h25, 32'h8000_0101},  // R6
        '{1'b1, 8'h26, 32'h8000_0000},  // R6 clear
        '{1'b0, 8'h26, 32'h0000_0101},  // R6 read via clear port
        '{1'b1, 8'h27, 32'h00FF_0000},  // R7 fall set
        '{1'b1, 8'h28, 32'h000F_0000},  // R7 fall clear
        '{1'b0, 8'h27, 32'h00F0_0000},  // R7
        '{1'b0, 8'h15, 32'h0000_0000},  // R13 bank0 rise untouched
        '{1'b1, 8'h00, 32'h1234_5678},  // R12 write ignored
        '{1'b0, 8'h00, 32'h0B10_0C01},  // R12
        '{1'b1, 8'h01, 32'h0000_0003},  // R11
        '{1'b0, 8'h01, 32'h0000_0003},  // R11
        '{1'b1, 8'h01, 32'h0000_0002},  // R11
        '{1'b0, 8'h01, 32'h0000_0002},  // R11
        '{1'b0, 8'h21, 32'h0000_0000}   // R13 bank1 latch untouched
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [BW-1:0]     bus_wdata = '0;
    logic [BW-1:0]     bus_rdata;
    logic [NB*BW-1:0]  pin_in = '0;
    logic [NB*BW-1:0]  pin_out;
    logic [NB*BW-1:0]  pin_oe;
    logic [NB-1:0]     irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        step();
        bus_we    = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, 64'(bus_rdata), 64'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_check("R1 dir", 8'h10, 32'hFFFF_FFFF);
        rd_check("R1 dir b1", 8'h20, 32'hFFFF_FFFF);
        rd_check("R1 stat", 8'h29, 32'h0);
        rd_check("R1 ben", 8'h01, 32'h0);
        check("R1 oe", pin_oe, 64'h0);
        check("R1 irq", 64'(irq), 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
            else rd_check($sformatf("vector %0d", i), VECS[i].addr, VECS[i].data);
        end

        // R2 R13 pin-level view of bank0 and bank1
        check("R2 oe", pin_oe, 64'h0000_0000_FFFF_0000);
        check("R3 pin_out", pin_out, 64'h0000_0000_A0A0_F00F);
        wr(8'h20, 32'hFFFF_FFFE);
        check("R13 oe pin32", pin_oe, 64'h0000_0001_FFFF_0000);

        // R5 synchroniser latency, pin 37 = bank1 bit5 (not rise-enabled)
        pin_in[37] = 1'b1;
        step();
        rd_check("R5 after one edge", 8'h24, 32'h0);
        step();
        rd_check("R5 after two edges", 8'h24, 32'h20);
        step();
        rd_check("R8 disabled edge", 8'h29, 32'h0);

        // R8 enabled rising edge on pin 40 = bank1 bit8
        pin_in[40] = 1'b1;
        step(); step();
        rd_check("R8 not yet", 8'h29, 32'h0);
        step();
        rd_check("R8 rise", 8'h29, 32'h100);
        check("R11 irq on", 64'(irq), 64'h2);

        // R7 R8 falling edge on pin 52 = bank1 bit20
        pin_in[52] = 1'b1;
        repeat (3) step();
        rd_check("R8 rise not enabled b20", 8'h29, 32'h100);
        pin_in[52] = 1'b0;
        repeat (3) step();
        rd_check("R7 fall", 8'h29, 32'h0010_0100);

        // R9 write-one-to-clear
        wr(8'h29, 32'h0000_0100);
        rd_check("R9 clear", 8'h29, 32'h0010_0000);

        // R10 edge and clear collide on bank1 bit0 (pin 32)
        pin_in[32] = 1'b1;
        repeat (3) step();
        rd_check("R10 setup", 8'h29, 32'h0010_0001);
        pin_in[32] = 1'b0;
        repeat (3) step();
        pin_in[32] = 1'b1;
        step(); step();
        wr(8'h29, 32'h0000_0001);
        rd_check("R10 collide", 8'h29, 32'h0010_0001);
        wr(8'h29, 32'h0000_0001);
        rd_check("R9 clear after", 8'h29, 32'h0010_0000);

        // R11 bank gating
        wr(8'h01, 32'h0);
        check("R11 irq gated", 64'(irq), 64'h0);
        wr(8'h01, 32'h2);
        check("R11 irq back", 64'(irq), 64'h2);
        wr(8'h29, 32'hFFFF_FFFF);
        check("R11 irq no status", 64'(irq), 64'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule